// File: doc/BRIEF.md
# PS/2 Keyboard and Mouse Frame Receiver

This block takes the two open-collector lines of a PS/2 port (a clock and a data line, both already resolved to input levels) and turns each serial frame sent by a keyboard or mouse into one parallel byte for the host logic. Both lines pass through a two-flop synchroniser. The clock line then passes through a stability filter. Only a filtered high-to-low transition of the bus clock samples the data line. Each frame has eleven bits: a start bit, eight data bits sent least significant first, an odd parity bit and a stop bit.

A frame state machine walks through four named states. `ST_IDLE` waits for the first falling edge, which carries the start bit. `ST_DATA` collects the eight data bits. `ST_PARITY` takes the parity bit. `ST_STOP` takes the stop bit and publishes the result. The transitions are:
- idle→data on any filtered falling edge.
- data→parity on the eighth data edge.
- parity→stop on the parity edge.
- stop→idle on the stop edge, which emits the byte.
- timeout from any of data, parity or stop back to idle, with no output.

The timeout fires when the bus clock stalls in the middle of a frame for longer than a programmable window, about 100 µs by default. At a 100 MHz system clock the default glitch window is 100 cycles (1 µs) and the default stall window is 10000 cycles.

A completed frame always produces a one-cycle valid pulse. The error flag is raised alongside that pulse when the start bit, the parity or the stop bit is wrong. The byte output holds its value until the next frame completes.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `rx_valid_o` is 0, `rx_byte_o` is 8'h00 and `rx_err_o` is 0.
- R2: A frame is start bit, eight data bits (bit 0 first), parity, stop, each sampled on a falling edge of `ps2_clk_i`. The assembled byte appears on `rx_byte_o` together with a `rx_valid_o` pulse no later than FILT_CYCLES+6 system cycles after the stop-bit falling edge.
- R3: Parity is odd: the eight data bits plus the parity bit must contain an odd number of ones. Otherwise `rx_err_o` is 1 in the valid cycle.
- R4: A start bit sampled as 1 still completes the frame, but sets `rx_err_o` to 1 in the valid cycle.
- R5: A stop bit sampled as 0 sets `rx_err_o` to 1 in the valid cycle. A well-formed frame gives `rx_err_o` = 0.
- R6: A low pulse on `ps2_clk_i` lasting fewer than FILT_CYCLES system cycles is ignored. It neither samples a bit nor disturbs the next frame.
- R7: If no falling edge arrives for TIMEOUT_CYCLES system cycles while a frame is partly received, the partial frame is discarded without a valid pulse. The next falling edge is then taken as a new start bit.
- R8: `rx_byte_o` and `rx_err_o` change only in a cycle where `rx_valid_o` is 1.
- R9: `rx_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | PS/2 clock line level, asynchronous |
| ps2_dat_i | input | 1 | PS/2 data line level, asynchronous |
| rx_valid_o | output | 1 | One-cycle pulse: a frame has completed |
| rx_byte_o | output | 8 | Last received data byte |
| rx_err_o | output | 1 | Error flag for the last frame (start, parity or stop) |

## Verification
A wrong bit counter or a missed or doubled edge shows up as a shifted byte, or as a frame that is swallowed into the next one. This is caught at the very next valid pulse by comparing it against the scoreboard. It is also caught by a latency check a few cycles after the stop edge. A filter that lets a glitch through shows the same misalignment on the frame that follows the glitch. A watchdog that does not clear leaves stale bits in the shifter, so the first byte after a stall comes out wrong. A wrong error decision is visible on `rx_err_o` in the same valid cycle as the byte.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int unsigned FRAME_DATA_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_t;

endpackage

// File: rtl/ps2_sync2.sv
module ps2_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                stab_q <= 1'b1;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end

        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/ps2_glitch_filter.sv
module ps2_glitch_filter #(
    parameter int unsigned FILT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);

    localparam int unsigned CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

    logic [CW-1:0] run_q;
    logic          level_q;
    logic          accept;

    assign accept = (line_i != level_q) && (run_q == CW'(FILT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_q <= 1'b1;
            fall_o  <= 1'b0;
        end else begin
            fall_o <= 1'b0;
            if (line_i == level_q) begin
                run_q <= '0;
            end else if (accept) begin
                run_q   <= '0;
                level_q <= line_i;
                fall_o  <= level_q & ~line_i;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    // R6: the filtered level only takes a value the synchronised line held
    p_level_follows_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(line_i) == level_q));

    // R6: a fall pulse only follows a drop of the filtered level
    p_fall_matches_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!level_q && $past(level_q)));

endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
    import ps2_rx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 10000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fall_i,
    input  logic                       dat_i,
    output logic                       valid_o,
    output logic [FRAME_DATA_BITS-1:0] byte_o,
    output logic                       err_o
);

    localparam int unsigned WW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int unsigned BW = $clog2(FRAME_DATA_BITS);

    rx_state_t                  state_q, state_d;
    logic [BW-1:0]              bit_idx_q;
    logic [FRAME_DATA_BITS-1:0] shift_q;
    logic                       start_bad_q;
    logic                       ones_q;
    logic [WW-1:0]              wd_q;
    logic                       timeout;

    assign timeout = (state_q != ST_IDLE) && !fall_i
                     && (wd_q == WW'(TIMEOUT_CYCLES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (timeout) state_d = ST_IDLE;
                else if (fall_i && bit_idx_q == BW'(FRAME_DATA_BITS - 1))
                    state_d = ST_PARITY;
            end
            ST_PARITY: begin
                if (timeout) state_d = ST_IDLE;
                else if (fall_i) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (timeout || fall_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath and stall watchdog
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx_q   <= '0;
            shift_q     <= '0;
            start_bad_q <= 1'b0;
            ones_q      <= 1'b0;
            wd_q        <= '0;
        end else begin
            if (state_q == ST_IDLE || fall_i || timeout) wd_q <= '0;
            else                                         wd_q <= wd_q + 1'b1;

            if (fall_i) begin
                unique case (state_q)
                    ST_IDLE: begin
                        start_bad_q <= dat_i;
                        bit_idx_q   <= '0;
                        ones_q      <= 1'b0;
                    end
                    ST_DATA: begin
                        shift_q   <= {dat_i, shift_q[FRAME_DATA_BITS-1:1]};
                        ones_q    <= ones_q ^ dat_i;
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                    ST_PARITY: ones_q <= ones_q ^ dat_i;
                    ST_STOP:   ;
                    default:   ;
                endcase
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            byte_o  <= '0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_STOP && fall_i) begin
                valid_o <= 1'b1;
                byte_o  <= shift_q;
                err_o   <= start_bad_q | ~ones_q | ~dat_i;
            end
        end
    end

    // R2: every valid pulse closes a frame that was in the stop state
    p_valid_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state_q) == ST_STOP && state_q == ST_IDLE));

    // R7: a stall inside a frame returns the machine to idle
    p_timeout_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (state_q == ST_IDLE && !valid_o));

    // R8: results hold between frames
    p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(byte_o) && $stable(err_o)));

    // R9: the valid strobe lasts one cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_rx_pkg::*;
#(
    parameter int unsigned FILT_CYCLES    = 100,
    parameter int unsigned TIMEOUT_CYCLES = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    output logic       rx_err_o
);

    localparam int unsigned LANES = 2;

    logic [LANES-1:0] synced;
    logic             clk_level;
    logic             clk_fall;

    ps2_sync2 #(.WIDTH(LANES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ps2_dat_i, ps2_clk_i}),
        .sync_o  (synced)
    );

    ps2_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (synced[0]),
        .level_o (clk_level),
        .fall_o  (clk_fall)
    );

    ps2_frame_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (clk_fall),
        .dat_i   (synced[1]),
        .valid_o (rx_valid_o),
        .byte_o  (rx_byte_o),
        .err_o   (rx_err_o)
    );

    // R2: a new byte is only published right after a clock-line edge was accepted
    p_valid_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(clk_fall) && !clk_level));

endmodule

// File: tb/sim_ps2_frame_rx.sv
module sim_ps2_frame_rx;

    localparam int FILT = 4;
    localparam int TMO  = 200;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pclk = 1'b1;
    logic       pdat = 1'b1;
    logic       valid;
    logic [7:0] rbyte;
    logic       rerr;

    int errors = 0;
    int checks = 0;
    int seen = 0;
    int pushed = 0;
    bit done = 0;

    logic [8:0] exp_q[$];
    logic       prev_valid = 1'b0;
    logic [7:0] last_byte = 8'h00;
    logic       last_err = 1'b0;

    always #5 clk = ~clk;

    ps2_frame_rx #(.FILT_CYCLES(FILT), .TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
        .rx_valid_o(valid), .rx_byte_o(rbyte), .rx_err_o(rerr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic bus_bit(input logic b);
        pdat = b;
        repeat (HALF) @(negedge clk);
        pclk = 1'b0;
        repeat (HALF) @(negedge clk);
        pclk = 1'b1;
    endtask

    // start/stop values given; flip_par corrupts the parity bit
    task automatic send_frame(input logic [7:0] d, input logic start_b,
                              input bit flip_par, input logic stop_b, input string req);
        logic par;
        logic e;
        par = ~(^d) ^ flip_par;
        e   = start_b | flip_par | ~stop_b;
        bus_bit(start_b);
        for (int i = 0; i < 8; i++) bus_bit(d[i]);
        bus_bit(par);
        exp_q.push_back({e, d});
        pushed++;
        pdat = stop_b;
        repeat (HALF) @(negedge clk);
        pclk = 1'b0;
        repeat (FILT + 6) @(negedge clk);
        check(seen == pushed, req, "byte delivered within latency", seen, pushed);
        repeat (HALF - FILT - 6) @(negedge clk);
        pclk = 1'b1;
        pdat = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check(!valid, "R9", "valid high two cycles", valid, 0);
            if (valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected byte", rbyte, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(rbyte == e[7:0], "R2", "byte value", rbyte, e[7:0]);
                    check(rerr == e[8], "R3/R4/R5", "error flag", rerr, e[8]);
                end
                last_byte = rbyte;
                last_err  = rerr;
            end else if (rbyte != last_byte || rerr != last_err) begin
                check(0, "R8", "output changed without valid", rbyte, last_byte);
                last_byte = rbyte;
                last_err  = rerr;
            end
            prev_valid = valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1", "valid after reset", valid, 0);
        check(rbyte == 8'h00, "R1", "byte after reset", rbyte, 0);
        check(rerr == 1'b0, "R1", "err after reset", rerr, 0);
        repeat (10) @(negedge clk);

        // R2 / R5: clean frames with varied patterns
        send_frame(8'hA5, 1'b0, 0, 1'b1, "R2");
        send_frame(8'h01, 1'b0, 0, 1'b1, "R2");
        send_frame(8'h80, 1'b0, 0, 1'b1, "R2");
        send_frame(8'hFF, 1'b0, 0, 1'b1, "R5");
        send_frame(8'h00, 1'b0, 0, 1'b1, "R2");
        // R3: bad parity
        send_frame(8'h3C, 1'b0, 1, 1'b1, "R3");
        // R4: start bit high
        send_frame(8'h5A, 1'b1, 0, 1'b1, "R4");
        // R5: stop bit low
        send_frame(8'hC3, 1'b0, 0, 1'b0, "R5");

        // R6: short glitches on the clock line, then a normal frame
        pdat = 1'b0;
        for (int g = 0; g < 3; g++) begin
            pclk = 1'b0;
            repeat (FILT - 2) @(negedge clk);
            pclk = 1'b1;
            repeat (15) @(negedge clk);
        end
        pdat = 1'b1;
        repeat (10) @(negedge clk);
        check(seen == pushed, "R6", "no byte from glitches", seen, pushed);
        send_frame(8'h96, 1'b0, 0, 1'b1, "R6");

        // R7: partial frame of start + 4 bits, then a stall
        bus_bit(1'b0);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        repeat (TMO + 60) @(negedge clk);
        check(seen == pushed, "R7", "no byte from stalled frame", seen, pushed);
        send_frame(8'h4E, 1'b0, 0, 1'b1, "R7");
        send_frame(8'h21, 1'b0, 0, 1'b1, "R8");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule